// File: doc/BRIEF.md
# Local TLB Invalidation Engine

This block owns a small set-associative translation store and clears the valid bit of entries selected by a local-invalidate command. A command chooses one of three scopes: every entry, every entry tagged with a given translation ID, or the entries that a given ID and effective address would hit. Entries with their protect bit set always survive. The engine walks the store one entry per cycle and holds `busy` high for the whole walk. When the walk ends, it pulses `done`, which the surrounding core uses as its request to flush any shadow translation caches.

Commands are privileged. A command that arrives while the core is in user mode, or that carries the reserved scope code, raises a one-cycle fault and leaves the store unchanged. A plain write port loads entries and a read port returns them with one cycle of latency. Both ports are meant for use while the engine is idle.

Top module: `tinv_engine`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `busy`, `done`, `fault_priv` and `fault_illegal` are all low.
- R2: An entry is 48 bits wide. Bit 47 is valid, bit 46 is protect, bit 45 is indirect, bit 44 is guest state, bits 43:40 are the size code, bits 39:32 are the translation ID, and bits 31:0 are the page address. The flat index is {array, set, way}. When `ent_wr_en` is high on a clock edge with `busy` low, the entry is written. `ent_rd_data` shows the entry at `ent_rd_idx` one cycle later. A write that arrives while `busy` is high is ignored.
- R3: Kind 0 clears the valid bit of every valid, unprotected entry.
- R4: Kind 1 clears the valid bit of every valid, unprotected entry whose translation ID equals `cmd_pid`. This applies across all arrays, sets and ways.
- R5: Kind 3 examines, in each array, only the ways of the set that EA bits [13:12] select. Entries in all other sets are left as they are, even if they would match.
- R6: Under kind 3, a way is cleared only if all of the following hold:
  - the translation ID equals `cmd_pid`;
  - the indirect bit equals `cmd_ind`;
  - the guest-state bit equals `cmd_gs`;
  - the EA and the page address agree on every bit at or above position 10 plus the size code (the page is 1 KiB shifted left by the size code).
- R7: No command kind ever clears an entry whose protect bit is set.
- R8: Kind 2 is reserved. It raises `fault_illegal` for exactly one cycle, on the cycle after acceptance. It does not raise `busy` or `done`, and it does not change the store.
- R9: When `cmd_user` is high, `fault_priv` rises for one cycle after acceptance and the store is unchanged. This check takes priority over the reserved-kind check.
- R10: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. `done` then goes high for one cycle, on the same cycle that `busy` goes low. With the default sizes this is the 18th cycle after acceptance for kinds 0 and 1, and the 6th for kind 3.
- R11: A command presented while `busy` is high is not taken. It has no effect on the store or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_kind | input | 2 | Scope code: 0 all, 1 by ID, 2 reserved, 3 by ID and address |
| cmd_ea | input | 32 | Effective address for kind 3 |
| cmd_pid | input | 8 | Translation ID searched for |
| cmd_ind | input | 1 | Indirect flag searched for |
| cmd_gs | input | 1 | Guest-state flag searched for |
| cmd_user | input | 1 | Issuer is in user mode |
| busy | output | 1 | Walk in progress; commands are stalled |
| done | output | 1 | Walk finished; translation cache flush request |
| fault_priv | output | 1 | Privilege fault pulse |
| fault_illegal | output | 1 | Reserved-kind fault pulse |
| ent_wr_en | input | 1 | Entry write strobe |
| ent_wr_idx | input | 4 | Entry write index |
| ent_wr_data | input | 48 | Entry write data |
| ent_rd_idx | input | 4 | Entry read index |
| ent_rd_data | output | 48 | Entry read data, one cycle latency |

## Verification
The directed cases are chosen so that each one separates a single pair of alternatives:
- Loading identical matching entries into every set, then issuing kind 3, shows whether only the set indexed by the EA is touched.
- Giving each way a different single mismatch (indirect bit, guest-state bit, translation ID, or an address bit just above the smallest page) shows which of the kind-3 conditions the engine honours.
- Repeating that case with a larger size code shows whether the address mask follows each entry's own page size.

Random stores then draw their IDs from a small pool and their page addresses from near the command EA, so hits and misses both occur often. Protected entries are mixed in throughout. Every command is checked for its exact walk length and fault behaviour. During one walk, a write and a reserved command are injected to show that both are ignored while the engine is busy.

// File: rtl/tinv_pkg.sv
package tinv_pkg;
  typedef enum logic [1:0] {
    INV_ALL    = 2'd0,
    INV_TID    = 2'd1,
    INV_RSVD   = 2'd2,
    INV_TID_EA = 2'd3
  } inv_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WALK  = 2'd1,
    SQ_DRAIN = 2'd2
  } sq_state_e;
endpackage

// File: rtl/tinv_store.sv
module tinv_store #(
  parameter int IDX_W   = 4,
  parameter int ENTRY_W = 48
) (
  input  logic               clk,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic [IDX_W-1:0]   raddr,
  output logic [ENTRY_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] mem [DEPTH];

  // one write port, one registered read port: simple dual-port RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tinv_match.sv
module tinv_match #(
  parameter int EA_W        = 32,
  parameter int PID_W       = 8,
  parameter int TS_W        = 4,
  parameter int PG_MIN_LOG2 = 10,
  parameter int ENTRY_W     = 48
) (
  input  logic [ENTRY_W-1:0] ent,
  input  logic [1:0]         kind,
  input  logic [EA_W-1:0]    ea,
  input  logic [PID_W-1:0]   pid,
  input  logic               sind,
  input  logic               sgs,
  output logic               hit
);
  import tinv_pkg::*;

  localparam int TID_LSB  = EA_W;
  localparam int TS_LSB   = EA_W + PID_W;
  localparam int GS_BIT   = TS_LSB + TS_W;
  localparam int IND_BIT  = GS_BIT + 1;
  localparam int PROT_BIT = IND_BIT + 1;
  localparam int VLD_BIT  = PROT_BIT + 1;
  localparam int SH_W     = $clog2(EA_W) + 2;

  logic [SH_W-1:0] sh;
  logic [EA_W-1:0] keep;
  logic            addr_ok, tid_ok, sel;

  always_comb begin
    // page is 1 << (PG_MIN_LOG2 + size code); compare only the page-number bits
    sh      = SH_W'(PG_MIN_LOG2) + SH_W'(ent[TS_LSB +: TS_W]);
    keep    = {EA_W{1'b1}} << sh;
    addr_ok = ((ea ^ ent[EA_W-1:0]) & keep) == '0;
    tid_ok  = ent[TID_LSB +: PID_W] == pid;
    unique case (inv_kind_e'(kind))
      INV_ALL:    sel = 1'b1;
      INV_TID:    sel = tid_ok;
      INV_TID_EA: sel = tid_ok && addr_ok &&
                        (ent[IND_BIT] == sind) && (ent[GS_BIT] == sgs);
      default:    sel = 1'b0;
    endcase
    hit = ent[VLD_BIT] && !ent[PROT_BIT] && sel;
  end
endmodule

// File: rtl/tinv_seq.sv
module tinv_seq #(
  parameter int ARR_LOG2 = 1,
  parameter int SET_LOG2 = 2,
  parameter int WAY_LOG2 = 1,
  parameter int EA_W     = 32,
  parameter int PID_W    = 8,
  parameter int SET_LSB  = 12,
  localparam int IDX_W   = ARR_LOG2 + SET_LOG2 + WAY_LOG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  input  logic [EA_W-1:0]  cmd_ea,
  input  logic [PID_W-1:0] cmd_pid,
  input  logic             cmd_ind,
  input  logic             cmd_gs,
  input  logic             cmd_user,
  output logic             busy,
  output logic             done,
  output logic             fault_priv,
  output logic             fault_illegal,
  output logic [IDX_W-1:0] walk_idx,
  output logic             p_vld,
  output logic [IDX_W-1:0] p_idx,
  output logic [1:0]       kind_q,
  output logic [EA_W-1:0]  ea_q,
  output logic [PID_W-1:0] pid_q,
  output logic             ind_q,
  output logic             gs_q
);
  import tinv_pkg::*;

  localparam int LOC_W = ARR_LOG2 + WAY_LOG2;
  localparam logic [IDX_W-1:0] LAST_LOC = IDX_W'((1 << LOC_W) - 1);
  localparam logic [IDX_W-1:0] LAST_ALL = '1;

  sq_state_e        state;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] last_cnt;

  assign busy = (state != SQ_IDLE);

  always_comb begin
    if (inv_kind_e'(kind_q) == INV_TID_EA) begin
      walk_idx = {cnt[LOC_W-1:WAY_LOG2], ea_q[SET_LSB +: SET_LOG2], cnt[WAY_LOG2-1:0]};
      last_cnt = LAST_LOC;
    end else begin
      walk_idx = cnt;
      last_cnt = LAST_ALL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= SQ_IDLE;
      cnt           <= '0;
      done          <= 1'b0;
      fault_priv    <= 1'b0;
      fault_illegal <= 1'b0;
      p_vld         <= 1'b0;
      p_idx         <= '0;
      kind_q        <= '0;
      ea_q          <= '0;
      pid_q         <= '0;
      ind_q         <= 1'b0;
      gs_q          <= 1'b0;
    end else begin
      done          <= 1'b0;
      fault_priv    <= 1'b0;
      fault_illegal <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          p_vld <= 1'b0;
          if (cmd_valid) begin
            if (cmd_user) fault_priv <= 1'b1;
            else if (inv_kind_e'(cmd_kind) == INV_RSVD) fault_illegal <= 1'b1;
            else begin
              state  <= SQ_WALK;
              cnt    <= '0;
              kind_q <= cmd_kind;
              ea_q   <= cmd_ea;
              pid_q  <= cmd_pid;
              ind_q  <= cmd_ind;
              gs_q   <= cmd_gs;
            end
          end
        end
        SQ_WALK: begin
          p_vld <= 1'b1;
          p_idx <= walk_idx;
          cnt   <= cnt + 1'b1;
          if (cnt == last_cnt) state <= SQ_DRAIN;
        end
        SQ_DRAIN: begin
          p_vld <= 1'b0;
          state <= SQ_IDLE;
          done  <= 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R11
  hold_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(kind_q) && $stable(ea_q) && $stable(pid_q)
                               && $stable(ind_q) && $stable(gs_q)));
  // R8
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, fault_priv, fault_illegal}));
  // R9
  fault_nowalk_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_priv || fault_illegal) |-> !busy);
endmodule

// File: rtl/tinv_engine.sv
module tinv_engine #(
  parameter int ARR_LOG2    = 1,
  parameter int SET_LOG2    = 2,
  parameter int WAY_LOG2    = 1,
  parameter int EA_W        = 32,
  parameter int PID_W       = 8,
  parameter int TS_W        = 4,
  parameter int PG_MIN_LOG2 = 10,
  parameter int SET_LSB     = 12,
  localparam int IDX_W      = ARR_LOG2 + SET_LOG2 + WAY_LOG2,
  localparam int ENTRY_W    = EA_W + PID_W + TS_W + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_kind,
  input  logic [EA_W-1:0]    cmd_ea,
  input  logic [PID_W-1:0]   cmd_pid,
  input  logic               cmd_ind,
  input  logic               cmd_gs,
  input  logic               cmd_user,
  output logic               busy,
  output logic               done,
  output logic               fault_priv,
  output logic               fault_illegal,
  input  logic               ent_wr_en,
  input  logic [IDX_W-1:0]   ent_wr_idx,
  input  logic [ENTRY_W-1:0] ent_wr_data,
  input  logic [IDX_W-1:0]   ent_rd_idx,
  output logic [ENTRY_W-1:0] ent_rd_data
);
  localparam int VLD_BIT  = ENTRY_W - 1;
  localparam int PROT_BIT = ENTRY_W - 2;

  logic [IDX_W-1:0]   walk_idx, p_idx, raddr, waddr;
  logic               p_vld, hit, wb_en, we;
  logic [1:0]         kind_q;
  logic [EA_W-1:0]    ea_q;
  logic [PID_W-1:0]   pid_q;
  logic               ind_q, gs_q;
  logic [ENTRY_W-1:0] rd_q, wdata;

  tinv_seq #(
    .ARR_LOG2(ARR_LOG2), .SET_LOG2(SET_LOG2), .WAY_LOG2(WAY_LOG2),
    .EA_W(EA_W), .PID_W(PID_W), .SET_LSB(SET_LSB)
  ) u_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_ea(cmd_ea),
    .cmd_pid(cmd_pid), .cmd_ind(cmd_ind), .cmd_gs(cmd_gs), .cmd_user(cmd_user),
    .busy(busy), .done(done), .fault_priv(fault_priv), .fault_illegal(fault_illegal),
    .walk_idx(walk_idx), .p_vld(p_vld), .p_idx(p_idx),
    .kind_q(kind_q), .ea_q(ea_q), .pid_q(pid_q), .ind_q(ind_q), .gs_q(gs_q)
  );

  tinv_match #(
    .EA_W(EA_W), .PID_W(PID_W), .TS_W(TS_W),
    .PG_MIN_LOG2(PG_MIN_LOG2), .ENTRY_W(ENTRY_W)
  ) u_match (
    .ent(rd_q), .kind(kind_q), .ea(ea_q), .pid(pid_q),
    .sind(ind_q), .sgs(gs_q), .hit(hit)
  );

  // walk write-back owns the write port while busy; loads only when idle
  assign wb_en = p_vld && hit;
  assign we    = wb_en || (ent_wr_en && !busy);
  assign waddr = wb_en ? p_idx : ent_wr_idx;
  assign wdata = wb_en ? (rd_q & ~(ENTRY_W'(1) << VLD_BIT)) : ent_wr_data;
  assign raddr = busy ? walk_idx : ent_rd_idx;

  tinv_store #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rd_q)
  );

  assign ent_rd_data = rd_q;

  // R7
  prot_keep_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> !rd_q[PROT_BIT]);
  // R2
  wb_in_walk_chk: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> busy);
endmodule

// File: tb/tb_tinv_engine.sv
`timescale 1ns/1ps
module tb_tinv_engine;
  localparam int ARR_LOG2 = 1, SET_LOG2 = 2, WAY_LOG2 = 1;
  localparam int EA_W = 32, PID_W = 8, TS_W = 4, PG_MIN_LOG2 = 10, SET_LSB = 12;
  localparam int IDX_W = ARR_LOG2 + SET_LOG2 + WAY_LOG2;
  localparam int ENTRY_W = EA_W + PID_W + TS_W + 4;
  localparam int N = 1 << IDX_W;
  localparam int LOC_N = 1 << (ARR_LOG2 + WAY_LOG2);
  localparam int VLD = ENTRY_W - 1, PROT = ENTRY_W - 2, IND = ENTRY_W - 3, GS = ENTRY_W - 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, cmd_valid, cmd_ind, cmd_gs, cmd_user;
  logic [1:0] cmd_kind;
  logic [EA_W-1:0] cmd_ea;
  logic [PID_W-1:0] cmd_pid;
  logic busy, done, fault_priv, fault_illegal, ent_wr_en;
  logic [IDX_W-1:0] ent_wr_idx, ent_rd_idx;
  logic [ENTRY_W-1:0] ent_wr_data, ent_rd_data;

  int checks = 0, errors = 0;
  logic [ENTRY_W-1:0] model [N];

  tinv_engine dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_ea(cmd_ea),
    .cmd_pid(cmd_pid), .cmd_ind(cmd_ind), .cmd_gs(cmd_gs), .cmd_user(cmd_user),
    .busy(busy), .done(done), .fault_priv(fault_priv), .fault_illegal(fault_illegal),
    .ent_wr_en(ent_wr_en), .ent_wr_idx(ent_wr_idx), .ent_wr_data(ent_wr_data),
    .ent_rd_idx(ent_rd_idx), .ent_rd_data(ent_rd_data)
  );

  function automatic logic [ENTRY_W-1:0] mk(input logic v, p, ind, gs,
      input logic [TS_W-1:0] ts, input logic [PID_W-1:0] tid, input logic [EA_W-1:0] epn);
    return {v, p, ind, gs, ts, tid, epn};
  endfunction

  function automatic bit ref_hit(input logic [ENTRY_W-1:0] e, input logic [1:0] kind,
      input logic [EA_W-1:0] ea, input logic [PID_W-1:0] pid, input logic ind, gs);
    int pg;
    bit tid_ok, addr_ok;
    if (!e[VLD] || e[PROT]) return 0;
    pg = PG_MIN_LOG2 + int'(e[EA_W+PID_W +: TS_W]);
    tid_ok = e[EA_W +: PID_W] == pid;
    addr_ok = 1;
    for (int b = pg; b < EA_W; b++) if (e[b] != ea[b]) addr_ok = 0;
    case (kind)
      2'd0: return 1;
      2'd1: return tid_ok;
      2'd3: return tid_ok && addr_ok && e[IND] == ind && e[GS] == gs;
      default: return 0;
    endcase
  endfunction

  function automatic bit in_scope(input int idx, input logic [1:0] kind, input logic [EA_W-1:0] ea);
    if (kind != 2'd3) return 1;
    return ((idx >> WAY_LOG2) & ((1 << SET_LOG2) - 1)) == int'(ea[SET_LSB +: SET_LOG2]);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [ENTRY_W-1:0] d);
    @(negedge clk);
    ent_wr_en = 1; ent_wr_idx = IDX_W'(idx); ent_wr_data = d;
    @(posedge clk);
    @(negedge clk);
    ent_wr_en = 0;
    model[idx] = d;
  endtask

  task automatic read_entry(input int idx, output logic [ENTRY_W-1:0] d);
    @(negedge clk);
    ent_rd_idx = IDX_W'(idx);
    @(posedge clk);
    @(negedge clk);
    d = ent_rd_data;
  endtask

  task automatic compare_all(input string req);
    logic [ENTRY_W-1:0] d;
    bit ok = 1;
    int bad = 0;
    logic [ENTRY_W-1:0] bad_act = '0, bad_exp = '0;
    for (int i = 0; i < N; i++) begin
      read_entry(i, d);
      if (d !== model[i] && ok) begin ok = 0; bad = i; bad_act = d; bad_exp = model[i]; end
    end
    check(ok, req, $sformatf("store entry %0d", bad), 64'(bad_act), 64'(bad_exp));
  endtask

  task automatic run_cmd(input logic [1:0] kind, input logic [EA_W-1:0] ea,
      input logic [PID_W-1:0] pid, input logic ind, gs, user, input bit poke, input string req);
    logic [ENTRY_W-1:0] expm [N];
    bit walk;
    int k, exp_k;
    walk = !user && kind != 2'd2;
    for (int i = 0; i < N; i++) begin
      expm[i] = model[i];
      if (walk && in_scope(i, kind, ea) && ref_hit(model[i], kind, ea, pid, ind, gs))
        expm[i][VLD] = 1'b0;
    end
    @(negedge clk);
    cmd_valid = 1; cmd_kind = kind; cmd_ea = ea; cmd_pid = pid;
    cmd_ind = ind; cmd_gs = gs; cmd_user = user;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    k = 1;
    while (!(done || fault_priv || fault_illegal) && k < 200) begin
      if (poke && k == 3) begin
        // R11 R2: command and write presented mid-walk must be dropped
        ent_wr_en = 1; ent_wr_idx = '0; ent_wr_data = '1;
        cmd_valid = 1; cmd_kind = 2'd2; cmd_user = 0;
      end
      @(posedge clk);
      @(negedge clk);
      ent_wr_en = 0; cmd_valid = 0;
      k++;
    end
    exp_k = walk ? ((kind == 2'd3) ? LOC_N + 2 : N + 2) : 1;
    // R10 walk length and completion pulse timing
    check(k == exp_k, req, "cycles to completion", 64'(k), 64'(exp_k));
    // R8 R9 which outcome
    check(done == walk && fault_priv == user && fault_illegal == (!user && kind == 2'd2) && !busy,
          req, "outcome {busy,done,fp,fi}", {busy, done, fault_priv, fault_illegal},
          {1'b0, walk, user, !user && kind == 2'd2});
    @(posedge clk);
    @(negedge clk);
    // R10 single-cycle pulse
    check(!done && !fault_priv && !fault_illegal && !busy, req, "pulse width",
          {busy, done, fault_priv, fault_illegal}, 0);
    for (int i = 0; i < N; i++) model[i] = expm[i];
    compare_all(req);
  endtask

  task automatic fill_random(input logic [EA_W-1:0] base);
    for (int i = 0; i < N; i++)
      load(i, mk(($urandom % 4) != 0, ($urandom % 4) == 0, $urandom % 2, $urandom % 2,
                 TS_W'($urandom % 4), PID_W'(1 + $urandom % 3),
                 base ^ (EA_W'($urandom) & 32'h0000_3C00)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [EA_W-1:0] ea;
    void'($urandom(32'h00C0FFEE));
    rst = 1; cmd_valid = 0; cmd_kind = 0; cmd_ea = 0; cmd_pid = 0;
    cmd_ind = 0; cmd_gs = 0; cmd_user = 0;
    ent_wr_en = 0; ent_wr_idx = 0; ent_wr_data = 0; ent_rd_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && !fault_priv && !fault_illegal, "R1", "outputs in reset",
          {busy, done, fault_priv, fault_illegal}, 0);
    rst = 0;
    @(negedge clk);
    check(!busy && !done && !fault_priv && !fault_illegal, "R1", "outputs after reset",
          {busy, done, fault_priv, fault_illegal}, 0);

    // R2 load and read back
    fill_random(32'h1234_5000);
    compare_all("R2");

    // R3 R7 invalidate all, protected survive
    run_cmd(2'd0, 0, 0, 0, 0, 0, 0, "R3");
    // R4 by ID
    fill_random(32'h1234_5000);
    run_cmd(2'd1, 0, 8'd1, 0, 0, 0, 0, "R4");

    // R5 identical matching entries in every set; only set 2 touched
    ea = 32'h0000_2000;
    for (int i = 0; i < N; i++) load(i, mk(1, 0, 0, 0, 0, 8'd5, ea));
    run_cmd(2'd3, ea, 8'd5, 0, 0, 0, 0, "R5");

    // R6 one mismatch per way in set 1, size code 0
    ea = 32'h0000_1400;
    load(2, mk(1, 0, 1, 0, 0, 8'd7, ea));            // indirect differs
    load(3, mk(1, 0, 0, 1, 0, 8'd7, ea));            // guest state differs
    load(10, mk(1, 0, 0, 0, 0, 8'd6, ea));           // ID differs
    load(11, mk(1, 0, 0, 0, 0, 8'd7, ea ^ 32'h400)); // address bit 10 differs
    run_cmd(2'd3, ea, 8'd7, 0, 0, 0, 0, "R6");
    // R6 size code 2 masks bit 10, entry now hits
    load(11, mk(1, 0, 0, 0, 2, 8'd7, ea ^ 32'h400));
    load(10, mk(1, 1, 0, 0, 0, 8'd7, ea));           // R7 protected, otherwise hits
    run_cmd(2'd3, ea, 8'd7, 0, 0, 0, 0, "R6");

    // R8 reserved kind
    fill_random(32'h0000_0000);
    run_cmd(2'd2, 0, 8'd1, 0, 0, 0, 0, "R8");
    // R9 user mode, also priority over reserved
    run_cmd(2'd3, 32'h0000_0000, 8'd1, 0, 0, 1, 0, "R9");
    run_cmd(2'd2, 0, 8'd1, 0, 0, 1, 0, "R9");
    run_cmd(2'd0, 0, 8'd1, 0, 0, 1, 0, "R9");

    // R11 R2 stalled command and write during a walk
    run_cmd(2'd1, 0, 8'd2, 0, 0, 0, 1, "R11");

    // random mix
    for (int it = 0; it < 40; it++) begin
      ea = EA_W'($urandom);
      fill_random(ea);
      run_cmd(2'($urandom % 4), ea, PID_W'(1 + $urandom % 3), $urandom % 2, $urandom % 2,
              ($urandom % 8) == 0, ($urandom % 5) == 0, "R6");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule